// File: doc/BRIEF.md
# Quad-SPI display command receiver

This block takes display traffic that a host sends over a four-bit serial link and turns it into tagged words for a FIFO that feeds a parallel display bus. The link has a serial clock, an active-low chip select and four data lines. The block resamples all of them in its own clock domain. It assembles two nibbles per byte, most significant nibble first. The first byte of each chip-select frame is the command and every later byte is data. No separate pin carries command-versus-data; the block derives it and writes it as a flag bit next to each word.

Two command codes, supplied on configuration inputs, start a pixel stream. After either code, following data bytes are packed in pairs into 16-bit colour words. After any other command, each parameter byte goes out alone, zero-extended. One private command code sets the maximum write rate of the parallel side. The block keeps that command and its first data byte, exposes the value on an output, and writes nothing to the FIFO for it. A write issued while the FIFO reports full sets a sticky overflow flag.

Top module: `qspi_cmd_rx`

## Requirements
- R1: After reset, fifo_wr_en and overflow are 0 and rate_value equals the parameter RATE_RESET (default 0x00).
- R2: While qspi_cs_n is low, each rising edge of qspi_sclk samples qspi_io as one nibble. The first nibble of a byte is bits 7:4 and the second is bits 3:0.
- R3: The first byte of a frame is written as a command entry: fifo_wr_data[16]=0, bits 15:8 zero, bits 7:0 the byte. The private rate code is the only exception.
- R4: After a command that is neither a pixel code nor the rate code, each data byte produces one entry with fifo_wr_data[16]=1, bits 15:8 zero and bits 7:0 the byte.
- R5: After a command equal to pix_code_a or pix_code_b, each pair of data bytes produces one entry with fifo_wr_data[16]=1, the first byte in bits 15:8 and the second in bits 7:0. Changing the code inputs changes which commands start pixel mode.
- R6: A command equal to RATE_CMD (default 0xE7), when it matches neither pixel code, is not written. The next data byte is loaded into rate_value and is not written. Later bytes in that frame are discarded. rate_value holds across frames.
- R7: Chip select rising after an incomplete byte, or after an unpaired pixel byte, discards the partial unit. The next frame starts again with a command byte and fresh pairing.
- R8: A write issued while fifo_full is 1 sets overflow, which stays 1 until reset.
- R9: Serial clock edges while chip select is high produce no writes. Two writes never occur in consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than twice the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qspi_sclk | input | 1 | Serial clock from the host |
| qspi_cs_n | input | 1 | Active-low frame select |
| qspi_io | input | 4 | Serial data nibble |
| pix_code_a | input | 8 | First command code that starts a pixel stream |
| pix_code_b | input | 8 | Second command code that starts a pixel stream |
| fifo_full | input | 1 | FIFO full indication |
| fifo_wr_en | output | 1 | One-cycle write strobe into the FIFO |
| fifo_wr_data | output | 17 | Data/command flag in bit 16, payload in bits 15:0 |
| overflow | output | 1 | Sticky overflow error |
| rate_value | output | 8 | Captured parallel write-rate setting |

## Verification
On every cycle, the assertions check several rules. Writes are isolated strobes that only come while the frame is selected. Command entries carry a zero upper byte. Overflow is sticky and rises only from a write made against a full FIFO. The rate value changes only inside a frame. Only the bench's frame scenarios can show that the right command is recognised and that pixel pairs are packed in the right order. They also show that the rate command and its value are swallowed and that aborted bytes and unpaired pixel bytes disappear at chip-select release.

// File: rtl/qspi_cmd_rx.sv
module qspi_cmd_rx #(
  parameter logic [7:0] RATE_CMD   = 8'hE7,
  parameter logic [7:0] RATE_RESET = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        qspi_sclk,
  input  logic        qspi_cs_n,
  input  logic [3:0]  qspi_io,
  input  logic [7:0]  pix_code_a,
  input  logic [7:0]  pix_code_b,
  input  logic        fifo_full,
  output logic        fifo_wr_en,
  output logic [16:0] fifo_wr_data,
  output logic        overflow,
  output logic [7:0]  rate_value
);

  typedef enum logic [2:0] {M_CMD, M_PARAM, M_PIXEL, M_RATE, M_SKIP} mode_t;

  logic [1:0] sclk_s, cs_s;
  logic [3:0] io_m, io_s;
  logic       sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_s <= 2'b00;
      cs_s   <= 2'b11;
      io_m   <= '0;
      io_s   <= '0;
      sclk_q <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[0], qspi_sclk};
      cs_s   <= {cs_s[0], qspi_cs_n};
      io_m   <= qspi_io;
      io_s   <= io_m;
      sclk_q <= sclk_s[1];
    end
  end

  wire cs_low  = !cs_s[1];
  wire edge_in = cs_low && sclk_s[1] && !sclk_q;

  mode_t      mode;
  logic       nib_phase, pix_half;
  logic [3:0] nib_hi;
  logic [7:0] pix_hi;

  wire        byte_done = edge_in && nib_phase;
  wire [7:0]  rx_byte   = {nib_hi, io_s};
  wire        is_pix    = (rx_byte == pix_code_a) || (rx_byte == pix_code_b);

  logic        emit;
  logic [16:0] word;

  always_comb begin
    emit = 1'b0;
    word = {1'b1, 8'h00, rx_byte};
    case (mode)
      M_CMD: begin
        emit = byte_done && (is_pix || rx_byte != RATE_CMD);
        word = {1'b0, 8'h00, rx_byte};
      end
      M_PARAM: emit = byte_done;
      M_PIXEL: begin
        emit = byte_done && pix_half;
        word = {1'b1, pix_hi, rx_byte};
      end
      default: emit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= M_CMD;
      nib_phase  <= 1'b0;
      pix_half   <= 1'b0;
      nib_hi     <= '0;
      pix_hi     <= '0;
      rate_value <= RATE_RESET;
    end else if (!cs_low) begin
      mode      <= M_CMD;
      nib_phase <= 1'b0;
      pix_half  <= 1'b0;
    end else if (edge_in) begin
      nib_phase <= !nib_phase;
      if (!nib_phase) nib_hi <= io_s;
      if (byte_done) begin
        case (mode)
          M_CMD:   mode <= is_pix ? M_PIXEL : (rx_byte == RATE_CMD) ? M_RATE : M_PARAM;
          M_PIXEL: begin
            pix_half <= !pix_half;
            if (!pix_half) pix_hi <= rx_byte;
          end
          M_RATE: begin
            rate_value <= rx_byte;
            mode       <= M_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_wr_en   <= 1'b0;
      fifo_wr_data <= '0;
      overflow     <= 1'b0;
    end else begin
      fifo_wr_en <= emit;
      if (emit) fifo_wr_data <= word;
      if (emit && fifo_full) overflow <= 1'b1;
    end
  end

  assert_write_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> $past(cs_low));
  assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |=> !fifo_wr_en);
  assert_cmd_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_en && !fifo_wr_data[16]) |-> fifo_wr_data[15:8] == 8'h00);
  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_overflow_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> fifo_wr_en && $past(fifo_full));
  assert_rate_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_value) |-> $past(cs_low));

endmodule

// File: tb/test_qspi_cmd_rx.sv
module test_qspi_cmd_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic qspi_sclk = 1'b0, qspi_cs_n = 1'b1;
  logic [3:0] qspi_io = '0;
  logic [7:0] pix_code_a = 8'h2C, pix_code_b = 8'h3C;
  logic fifo_full = 1'b0;
  logic fifo_wr_en, overflow;
  logic [16:0] fifo_wr_data;
  logic [7:0] rate_value;

  localparam logic [7:0] RATE = 8'hE7;

  qspi_cmd_rx i_qspi_cmd_rx (.*);

  always #10 clk = !clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [16:0] got [0:15];
  int got_n = 0;
  logic [16:0] exp_w [0:15];
  int exp_n;
  logic [7:0] tx [0:7];

  always @(negedge clk) begin
    if (fifo_wr_en && got_n < 16) begin
      got[got_n] = fifo_wr_data;
      got_n = got_n + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog R9: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic nibble(input logic [3:0] n);
    @(negedge clk) qspi_io = n;
    repeat (4) @(negedge clk);
    qspi_sclk = 1'b1;
    repeat (4) @(negedge clk);
    qspi_sclk = 1'b0;
  endtask

  task automatic frame(input int n, input bit extra);
    got_n = 0;
    @(negedge clk) qspi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      nibble(tx[i][7:4]);
      nibble(tx[i][3:0]);
    end
    if (extra) nibble(4'hA);
    repeat (4) @(negedge clk);
    qspi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic compare(input string tag);
    bit ok = (got_n == exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (got[i] !== exp_w[i]) ok = 0;
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual n=%0d first=%h expected n=%0d first=%h",
               tag, got_n, got[0], exp_n, exp_w[0]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wr_en", {31'd0, fifo_wr_en}, 0);
    chk("R1 overflow", {31'd0, overflow}, 0);
    chk("R1 rate", {24'd0, rate_value}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    got_n = 0;
    for (int i = 0; i < 6; i++) begin
      repeat (4) @(negedge clk) qspi_sclk = 1'b1;
      repeat (4) @(negedge clk) qspi_sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk("R9 idle sclk", got_n, 0);

    for (int c = 0; c < 256; c++) begin
      tx[0] = 8'(c);
      tx[1] = 8'(c) ^ 8'h5A;
      tx[2] = 8'(c + 3);
      tx[3] = ~8'(c);
      tx[4] = 8'(c * 7);
      frame(5, 0);
      if (tx[0] == 8'h2C || tx[0] == 8'h3C) begin
        exp_n = 3;
        exp_w[0] = {9'd0, tx[0]};
        exp_w[1] = {1'b1, tx[1], tx[2]};
        exp_w[2] = {1'b1, tx[3], tx[4]};
        compare("R5 pixel pack");
      end else if (tx[0] == RATE) begin
        exp_n = 0;
        compare("R6 rate swallowed");
        chk("R6 rate value", {24'd0, rate_value}, {24'd0, tx[1]});
      end else begin
        exp_n = 5;
        exp_w[0] = {9'd0, tx[0]};
        for (int i = 1; i < 5; i++) exp_w[i] = {9'h100, tx[i]};
        compare("R2 R3 R4 command and params");
      end
    end
    chk("R6 rate held", {24'd0, rate_value}, {24'd0, RATE ^ 8'h5A});

    pix_code_a = 8'h10; pix_code_b = 8'h11;
    tx[0] = 8'h2C; tx[1] = 8'h12; tx[2] = 8'h34;
    frame(3, 0);
    exp_n = 3; exp_w[0] = {9'd0, 8'h2C}; exp_w[1] = {9'h100, 8'h12}; exp_w[2] = {9'h100, 8'h34};
    compare("R5 old code now param");
    tx[0] = 8'h11;
    frame(3, 0);
    exp_n = 2; exp_w[0] = {9'd0, 8'h11}; exp_w[1] = {1'b1, 8'h12, 8'h34};
    compare("R5 new code pixel");
    pix_code_a = 8'h2C; pix_code_b = 8'h3C;

    tx[0] = 8'h2C; tx[1] = 8'hAB; tx[2] = 8'hCD; tx[3] = 8'hEF;
    frame(4, 0);
    exp_n = 2; exp_w[0] = {9'd0, 8'h2C}; exp_w[1] = {1'b1, 8'hAB, 8'hCD};
    compare("R7 odd pixel dropped");
    tx[0] = 8'h3C; tx[1] = 8'h01; tx[2] = 8'h02;
    frame(3, 0);
    exp_n = 2; exp_w[0] = {9'd0, 8'h3C}; exp_w[1] = {1'b1, 8'h01, 8'h02};
    compare("R7 pairing restarts");
    tx[0] = 8'h05; tx[1] = 8'h77;
    frame(2, 1);
    exp_n = 2; exp_w[0] = {9'd0, 8'h05}; exp_w[1] = {9'h100, 8'h77};
    compare("R7 half byte dropped");
    tx[0] = 8'h06;
    frame(1, 0);
    exp_n = 1; exp_w[0] = {9'd0, 8'h06};
    compare("R7 next frame is command");

    tx[0] = RATE; tx[1] = 8'h9A; tx[2] = 8'h11;
    frame(3, 0);
    exp_n = 0;
    compare("R6 extra bytes discarded");
    chk("R6 first byte kept", {24'd0, rate_value}, 32'h9A);

    chk("R8 no overflow yet", {31'd0, overflow}, 0);
    fifo_full = 1'b1;
    tx[0] = 8'h01;
    frame(1, 0);
    fifo_full = 1'b0;
    chk("R8 overflow set", {31'd0, overflow}, 1);
    frame(1, 0);
    chk("R8 overflow sticky", {31'd0, overflow}, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule